// File: doc/BRIEF.md
# Harmonic-Cancelling Direct Digital Synthesizer

This block is a direct digital synthesizer that feeds a 14-bit DAC with one sine sample on every clock. A 48-bit phase accumulator advances by a frequency tuning word each cycle. The truncated phase drives a sine lookup that is built at elaboration time.

Two cancellation channels run beside the fundamental path. Each one tracks an integer multiple (2 to 15) of the fundamental phase. It rotates that phase by a signed offset of up to half a turn, scales the harmonic sine by an 8-bit magnitude, and can double the result with a one-bit shift. The fundamental is scaled down slightly to leave room for both cancellation terms. The three terms are summed and clamped to the signed 14-bit range, and the result is sent out as an offset-binary DAC word.

A fundamental-disable input leaves only the cancellation terms at the output, which lets the cancellation amplitude be matched to a measured spur. A phase-reset pulse clears the accumulator and leaves every setting unchanged.

Top module: `dds_spur_cancel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dac_word` becomes 14'h2000 (midscale) after that edge and the accumulator becomes zero.
- R2: The accumulator adds `ftw` modulo 2^48 on every clock. The working phase P is its upper 19 bits, acc[47:29].
- R3: The sine of a 10-bit index i (the upper 10 bits of a 19-bit phase) is computed as follows. Let q = i[9:8] and j = i[7:0]. Let k = j when q is even and k = 255−j when q is odd. Then v = round(8191·sin(π·(2k+1)/1024)), and the sine is +v for q < 2 and −v for q ≥ 2.
- R4: When enabled, the fundamental term is s − floor(s/32), where s is the sine of P[18:9].
- R5: The phase of channel c is (n·P + o·2^10) mod 2^19. Here n is `ch_harm[c]` and o is `ch_ofs[c]` read as a signed 9-bit half-turn fraction. The channel's sine is taken from the upper 10 bits of that phase.
- R6: The cancellation term is floor(s·m/2^14), where m is the unsigned `ch_mag[c]`. When `ch_gain[c]` is 1, the term is doubled.
- R7: A channel whose enable is 0 or whose harmonic number is below 2 contributes exactly zero.
- R8: When `fund_off` is 1, the fundamental term is zero and only the enabled channels reach the output.
- R9: The sum of the three terms is clamped to the range −8192 to 8191. `dac_word` equals the clamped sum plus 8192.
- R10: A `dds_rst` pulse sets the accumulator to zero on that edge, taking precedence over the addition. Channel and fundamental settings are unaffected.
- R11: Every input present before clock edge e, together with the accumulator value before edge e, appears in `dac_word` right after edge e+3. This latency is the same for every path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ftw | input | 48 | Frequency tuning word |
| fund_off | input | 1 | Removes the fundamental term when 1 |
| dds_rst | input | 1 | Clears the phase accumulator |
| ch_en | input | 2 | Per-channel enable |
| ch_harm | input | 2x4 | Per-channel harmonic number |
| ch_ofs | input | 2x9 | Per-channel signed phase offset, half-turn fraction |
| ch_mag | input | 2x8 | Per-channel cancellation magnitude |
| ch_gain | input | 2 | Per-channel doubling shift |
| dac_word | output | 14 | Offset-binary DAC sample |

## Verification
The case that matters most is a phase-reset pulse that lands in the same cycle as a channel being switched off. The bench forces this coincidence in a directed sequence. It also lets the two events collide at random during a long stretch in which every control changes on every cycle. Each output sample is compared with a bench model that zeroes its own accumulator copy and applies the new settings exactly three edges after that cycle. The second overlap is clamping together with a control change. A setting with both channels at full boosted magnitude on the fifth harmonic drives the sum past both rails, and the bench confirms that both the high and the low clamp were reached.

// File: rtl/dds_sc_pkg.sv
// Package: shared defaults and the elaboration-time quarter-wave sine generator.
// Assumes real arithmetic is only evaluated as a constant function.
package dds_sc_pkg;
    localparam int ACC_W_DEF     = 48;
    localparam int PH_W_DEF      = 19;
    localparam int IDX_W_DEF     = 10;
    localparam int AMP_W_DEF     = 14;
    localparam int HARM_W_DEF    = 4;
    localparam int OFS_W_DEF     = 9;
    localparam int MAG_W_DEF     = 8;
    localparam int NUM_CH_DEF    = 2;
    localparam int HEADROOM_DEF  = 5;
    localparam int CANCEL_SH_DEF = 14;
    localparam real SINE_PI      = 3.14159265358979;

    // Rounded peak*sin of the centre of quarter-wave bin k out of qn bins.
    function automatic int quarter_sine(int k, int qn, int peak);
        real ang;
        ang = SINE_PI * real'(2 * k + 1) / (4.0 * real'(qn));
        return $rtoi(real'(peak) * $sin(ang) + 0.5);
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator: adds the tuning word every clock and exposes the
// truncated phase. Assumes dds_rst is a synchronous pulse.
module dds_phase_acc #(
    parameter int ACC_W = 48,
    parameter int PH_W  = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dds_rst,
    input  logic [ACC_W-1:0] ftw,
    output logic [PH_W-1:0]  phase
);
    logic [ACC_W-1:0] acc_q;

    // Accumulate, or clear on reset or phase-reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || dds_rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + ftw;
        end
    end

    assign phase = acc_q[ACC_W-1 -: PH_W];

    // R2: accumulator advances by the tuning word
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(dds_rst) |-> acc_q == $past(acc_q) + $past(ftw));

    // R10: phase-reset pulse zeroes the accumulator
    p_dds_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dds_rst) |-> acc_q == '0);
endmodule

// File: rtl/dds_harm_phase.sv
// Harmonic phase stage: multiplies the fundamental phase by n, adds a
// half-turn offset, keeps the LUT index. Assumes harmonic numbers below
// 2 are invalid and mute the channel.
module dds_harm_phase #(
    parameter int PH_W   = 19,
    parameter int IDX_W  = 10,
    parameter int HARM_W = 4,
    parameter int OFS_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              en,
    input  logic [HARM_W-1:0] harm,
    input  logic [OFS_W-1:0]  ofs,
    output logic [IDX_W-1:0]  idx_out,
    output logic              on_out
);
    localparam int PAD_W = PH_W - OFS_W;
    localparam int DROP  = PH_W - IDX_W;

    logic [PH_W-1:0] prod;
    logic [PH_W-1:0] rot;

    // Harmonic product modulo one turn and offset rotation.
    always_comb begin
        prod = phase * PH_W'(harm);
        rot  = {ofs, {PAD_W{1'b0}}};
    end

    // Register truncated index and channel-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_out <= '0;
            on_out  <= 1'b0;
        end else begin
            idx_out <= IDX_W'((prod + rot) >> DROP);
            on_out  <= en && (harm >= HARM_W'(2));
        end
    end

    // R7: disabled or invalid harmonic channel is marked inactive
    p_mute_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || harm < HARM_W'(2)) |=> !on_out);
endmodule

// File: rtl/dds_sine_lut.sv
// Sine conversion: quarter-wave table generated at elaboration, folded to
// a full wave, one register stage. Assumes IDX_W >= 3.
module dds_sine_lut
    import dds_sc_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int AMP_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    on_in,
    output logic signed [AMP_W-1:0] amp_out,
    output logic                    on_out
);
    localparam int QW   = IDX_W - 2;
    localparam int QN   = 2 ** QW;
    localparam int PEAK = 2 ** (AMP_W - 1) - 1;

    logic [AMP_W-2:0] quarter [QN];

    for (genvar k = 0; k < QN; k++) begin : g_quarter
        localparam int QV = quarter_sine(k, QN, PEAK);
        assign quarter[k] = QV[AMP_W-2:0];
    end

    logic [QW-1:0]    fold;
    logic [AMP_W-2:0] mag_q;

    // Mirror the index in odd quadrants and fetch the magnitude.
    always_comb begin
        fold  = idx[IDX_W-2] ? ~idx[QW-1:0] : idx[QW-1:0];
        mag_q = quarter[fold];
    end

    // Apply the sign of the lower half-turn and register the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_out <= '0;
            on_out  <= 1'b0;
        end else begin
            amp_out <= idx[IDX_W-1] ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
            on_out  <= on_in;
        end
    end
endmodule

// File: rtl/dds_cancel_scale.sv
// Cancellation scaler: amplitude times magnitude, fixed right shift,
// optional doubling, zero when inactive. Assumes SHIFT < AMP_W + MAG_W.
module dds_cancel_scale #(
    parameter int AMP_W = 14,
    parameter int MAG_W = 8,
    parameter int SHIFT = 14,
    parameter int TW    = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [AMP_W-1:0] amp,
    input  logic                    on_in,
    input  logic [MAG_W-1:0]        mag,
    input  logic                    gain,
    output logic signed [TW-1:0]    term
);
    localparam int PW = AMP_W + MAG_W + 1;
    localparam int CW = PW - SHIFT;

    logic signed [CW-1:0] scaled;
    logic signed [TW-1:0] boosted;

    // Scale by magnitude with floor shift, then optional doubling.
    always_comb begin
        scaled  = CW'((PW'(amp) * PW'($signed({1'b0, mag}))) >>> SHIFT);
        boosted = gain ? (TW'(scaled) <<< 1) : TW'(scaled);
    end

    // Register the term, forcing zero for an inactive channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term <= '0;
        end else begin
            term <= on_in ? boosted : '0;
        end
    end

    // R7: inactive channel contributes exactly zero
    p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !on_in |=> term == '0);

    // R6: doubled term is always even
    p_boost_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on_in && gain |=> !term[0]);
endmodule

// File: rtl/dds_spur_cancel.sv
// Top: accumulator, fundamental plus NUM_CH harmonic phase paths, shared
// sine conversion, scaling with headroom, clamped sum and offset-binary
// output. Four register stages after the accumulator on every path.
module dds_spur_cancel
    import dds_sc_pkg::*;
#(
    parameter int ACC_W     = ACC_W_DEF,
    parameter int PH_W      = PH_W_DEF,
    parameter int IDX_W     = IDX_W_DEF,
    parameter int AMP_W     = AMP_W_DEF,
    parameter int HARM_W    = HARM_W_DEF,
    parameter int OFS_W     = OFS_W_DEF,
    parameter int MAG_W     = MAG_W_DEF,
    parameter int NUM_CH    = NUM_CH_DEF,
    parameter int HEADROOM  = HEADROOM_DEF,
    parameter int CANCEL_SH = CANCEL_SH_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ACC_W-1:0]               ftw,
    input  logic                           fund_off,
    input  logic                           dds_rst,
    input  logic [NUM_CH-1:0]              ch_en,
    input  logic [NUM_CH-1:0][HARM_W-1:0]  ch_harm,
    input  logic [NUM_CH-1:0][OFS_W-1:0]   ch_ofs,
    input  logic [NUM_CH-1:0][MAG_W-1:0]   ch_mag,
    input  logic [NUM_CH-1:0]              ch_gain,
    output logic [AMP_W-1:0]               dac_word
);
    localparam int NPATH = NUM_CH + 1;
    localparam int TW    = AMP_W + 1;
    localparam int SW    = AMP_W + 3;
    localparam logic signed [SW-1:0] SAT_HI = SW'(2 ** (AMP_W - 1) - 1);
    localparam logic signed [SW-1:0] SAT_LO = -SW'(2 ** (AMP_W - 1));

    logic [PH_W-1:0] ph_acc;

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .dds_rst (dds_rst),
        .ftw     (ftw),
        .phase   (ph_acc)
    );

    // ---- stage A: phase indices ----
    logic [IDX_W-1:0] fund_idx_a;
    logic             fund_on_a;
    logic [IDX_W-1:0] ch_idx_a [NUM_CH];
    logic             ch_on_a  [NUM_CH];
    logic [MAG_W-1:0] mag_a    [NUM_CH];
    logic             gain_a   [NUM_CH];
    logic [MAG_W-1:0] mag_b    [NUM_CH];
    logic             gain_b   [NUM_CH];

    // Register the fundamental index and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fund_idx_a <= '0;
            fund_on_a  <= 1'b0;
        end else begin
            fund_idx_a <= ph_acc[PH_W-1 -: IDX_W];
            fund_on_a  <= !fund_off;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_a
        dds_harm_phase #(
            .PH_W(PH_W), .IDX_W(IDX_W), .HARM_W(HARM_W), .OFS_W(OFS_W)
        ) u_harm (
            .clk     (clk),
            .rst_n   (rst_n),
            .phase   (ph_acc),
            .en      (ch_en[c]),
            .harm    (ch_harm[c]),
            .ofs     (ch_ofs[c]),
            .idx_out (ch_idx_a[c]),
            .on_out  (ch_on_a[c])
        );

        // Carry magnitude and gain alongside the phase through A and B.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mag_a[c]  <= '0;
                gain_a[c] <= 1'b0;
                mag_b[c]  <= '0;
                gain_b[c] <= 1'b0;
            end else begin
                mag_a[c]  <= ch_mag[c];
                gain_a[c] <= ch_gain[c];
                mag_b[c]  <= mag_a[c];
                gain_b[c] <= gain_a[c];
            end
        end
    end

    // ---- stage B: sine conversion on every path ----
    logic [IDX_W-1:0]        path_idx [NPATH];
    logic                    path_on  [NPATH];
    logic signed [AMP_W-1:0] amp_b    [NPATH];
    logic                    on_b     [NPATH];

    assign path_idx[0] = fund_idx_a;
    assign path_on[0]  = fund_on_a;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_path_map
        assign path_idx[c+1] = ch_idx_a[c];
        assign path_on[c+1]  = ch_on_a[c];
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_lut
        dds_sine_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_lut (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (path_idx[p]),
            .on_in   (path_on[p]),
            .amp_out (amp_b[p]),
            .on_out  (on_b[p])
        );
    end

    // ---- stage C: scaled terms ----
    logic signed [TW-1:0] fund_term_c;
    logic signed [TW-1:0] ch_term_c [NUM_CH];

    // Fundamental with headroom taken off, or zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fund_term_c <= '0;
        end else begin
            fund_term_c <= on_b[0] ? (TW'(amp_b[0]) - TW'(amp_b[0] >>> HEADROOM)) : '0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_scale
        dds_cancel_scale #(
            .AMP_W(AMP_W), .MAG_W(MAG_W), .SHIFT(CANCEL_SH), .TW(TW)
        ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .amp   (amp_b[c+1]),
            .on_in (on_b[c+1]),
            .mag   (mag_b[c]),
            .gain  (gain_b[c]),
            .term  (ch_term_c[c])
        );
    end

    // ---- stage D: sum, clamp, offset-binary ----
    logic signed [SW-1:0]    sum_d;
    logic signed [AMP_W-1:0] clamp_d;

    // Add all terms and clamp into the signed output range.
    always_comb begin
        sum_d = SW'(fund_term_c);
        for (int c = 0; c < NUM_CH; c++) begin
            sum_d = sum_d + SW'(ch_term_c[c]);
        end
        if (sum_d > SAT_HI) begin
            clamp_d = AMP_W'(SAT_HI);
        end else if (sum_d < SAT_LO) begin
            clamp_d = AMP_W'(SAT_LO);
        end else begin
            clamp_d = AMP_W'(sum_d);
        end
    end

    // Register the DAC word with the sign bit inverted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word <= {1'b1, {(AMP_W-1){1'b0}}};
        end else begin
            dac_word <= {~clamp_d[AMP_W-1], clamp_d[AMP_W-2:0]};
        end
    end

    // R9: positive overflow clamps to the top code
    p_sat_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_d > SAT_HI |=> dac_word == '1);

    // R9: negative overflow clamps to the bottom code
    p_sat_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_d < SAT_LO |=> dac_word == '0);
endmodule

// File: tb/tb_dds_spur_cancel.sv
module tb_dds_spur_cancel;
    logic clk = 1'b0;
    logic rst_n, fund_off, dds_rst;
    logic [47:0] ftw;
    logic [1:0] ch_en, ch_gain;
    logic [1:0][3:0] ch_harm;
    logic [1:0][8:0] ch_ofs;
    logic [1:0][7:0] ch_mag;
    logic [13:0] dac_word;

    always #10 clk = ~clk;

    dds_spur_cancel dut (
        .clk(clk), .rst_n(rst_n), .ftw(ftw), .fund_off(fund_off), .dds_rst(dds_rst),
        .ch_en(ch_en), .ch_harm(ch_harm), .ch_ofs(ch_ofs), .ch_mag(ch_mag),
        .ch_gain(ch_gain), .dac_word(dac_word)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int sat_hi = 0;
    int sat_lo = 0;
    bit done = 0;
    logic [47:0] acc_m = '0;
    int exp_q [4];
    string tag_q [4];

    // R3 sine reference
    function automatic int sine_ref(int idx);
        int q, j, k, v;
        q = (idx >> 8) & 3;
        j = idx & 255;
        k = (q % 2 == 1) ? 255 - j : j;
        v = $rtoi(8191.0 * $sin(3.14159265358979 * real'(2 * k + 1) / 1024.0) + 0.5);
        return (q >= 2) ? -v : v;
    endfunction

    // Expected DAC word from R2..R9 for the current inputs and accumulator
    function automatic int model_word(logic [47:0] acc);
        int p, s, t, hp, sum;
        p = int'(acc[47:29]);
        sum = 0;
        if (!fund_off) begin
            s = sine_ref(p >> 9);
            sum += s - (s >>> 5);
        end
        for (int c = 0; c < 2; c++) begin
            if (ch_en[c] && ch_harm[c] >= 2) begin
                hp = (p * int'(ch_harm[c]) + (int'($signed(ch_ofs[c])) * 1024)) & 32'h7FFFF;
                s = sine_ref(hp >> 9);
                t = (s * int'(ch_mag[c])) >>> 14;
                if (ch_gain[c]) t = t * 2;
                sum += t;
            end
        end
        if (sum > 8191) begin sum = 8191; sat_hi++; end
        if (sum < -8192) begin sum = -8192; sat_lo++; end
        return (sum + 8192) & 16'h3FFF;
    endfunction

    task automatic check(string tag, int got, int expv);
        n_cmp++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    // One clock: model the inputs, advance, compare the sample due now (R11)
    task automatic step(string tag);
        int e;
        e = rst_n ? model_word(acc_m) : 32'h2000;
        @(posedge clk);
        if (!rst_n || dds_rst) acc_m = '0;
        else acc_m = acc_m + ftw;
        for (int i = 3; i > 0; i--) begin
            exp_q[i] = exp_q[i-1];
            tag_q[i] = tag_q[i-1];
        end
        exp_q[0] = e;
        tag_q[0] = tag;
        @(negedge clk);
        check(tag_q[3], int'(dac_word), exp_q[3]);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            exp_q[i] = 32'h2000;
            tag_q[i] = "R1";
        end
        rst_n = 1'b0; dds_rst = 1'b0; fund_off = 1'b0;
        ftw = 48'(521) << 29;
        ch_en = 2'b11; ch_gain = 2'b11;
        ch_harm = {4'd3, 4'd5}; ch_ofs = '0; ch_mag = {8'd255, 8'd255};
        @(negedge clk);
        // R1: reset holds midscale despite active settings
        run(4, "R1");
        check("R1", int'(dac_word), 32'h2000);
        rst_n = 1'b1;
        ch_en = 2'b00;

        // R2/R3/R4: fundamental only, two tuning words
        run(1100, "R4");
        ftw = 48'h0123_4567_89AB;
        run(600, "R2");
        ftw = 48'h7FFF_FFFF_FFFF;
        run(300, "R3");

        // R5/R6/R7: sweep harmonics, offsets, gain on each channel alone
        fund_off = 1'b1;
        ftw = 48'h0004_1A2B_3C4D;
        for (int c = 0; c < 2; c++) begin
            for (int n = 0; n < 16; n++) begin
                for (int oi = 0; oi < 4; oi++) begin
                    for (int g = 0; g < 2; g++) begin
                        ch_en = '0;
                        ch_en[c] = 1'b1;
                        ch_harm[c] = 4'(n);
                        ch_ofs[c] = (oi == 0) ? 9'd0 : (oi == 1) ? 9'd100 : (oi == 2) ? 9'h100 : 9'd255;
                        ch_mag[c] = g ? 8'd200 : 8'd255;
                        ch_gain[c] = 1'(g);
                        run(150, (n < 2) ? "R7" : (g ? "R6" : "R5"));
                    end
                end
            end
        end

        // R8: both channels with fundamental toggled off and on
        ch_en = 2'b11; ch_harm = {4'd7, 4'd2}; ch_ofs = {9'd40, 9'h1C0};
        ch_mag = {8'd90, 8'd180}; ch_gain = 2'b10;
        run(400, "R8");
        fund_off = 1'b0;
        run(400, "R8");

        // R9: fifth harmonic at full boosted magnitude pushes past both rails
        ftw = 48'(521) << 29;
        ch_harm = {4'd5, 4'd5}; ch_ofs = '0; ch_mag = {8'd255, 8'd255}; ch_gain = 2'b11;
        sat_hi = 0; sat_lo = 0;
        run(1200, "R9");
        n_cmp++;
        if (sat_hi == 0 || sat_lo == 0) begin
            n_bad++;
            $display("FAIL R9: clamp hits hi=%0d lo=%0d expected both >0", sat_hi, sat_lo);
        end

        // R10: phase reset together with a channel disable, then frozen phase
        run(37, "R10");
        dds_rst = 1'b1; ch_en[0] = 1'b0;
        step("R10");
        dds_rst = 1'b0; ftw = '0;
        run(12, "R10");
        ftw = 48'h0000_3000_0001;
        run(40, "R10");

        // R11: every control changes every cycle
        for (int i = 0; i < 20000; i++) begin
            ftw = {16'($urandom), $urandom};
            fund_off = ($urandom % 4) == 0;
            dds_rst = ($urandom % 16) == 0;
            ch_en = 2'($urandom);
            ch_gain = 2'($urandom);
            ch_harm = 8'($urandom);
            ch_ofs = 18'($urandom);
            ch_mag = 16'($urandom);
            step("R11");
        end
        dds_rst = 1'b0;
        run(4, "R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11: watchdog expired, got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule